// File: doc/BRIEF.md
# Real-time clock prescaler with second and minute timing signals

This block turns a 32.768 kHz time-base clock into the slow timing signals that a real-time clock needs. One binary divider chain, running on the time-base clock itself, yields a 128 Hz square wave for trimming the oscillator and a 1 Hz seconds square wave, SEC. A second stage counts SEC falling edges and flips a minute square wave, MIN, so that MIN has a 60 s period and spends 30 s high and 30 s low.

Two single-cycle strobes go to downstream logic. One marks each falling edge of SEC and the other each falling edge of MIN. The falling edge of MIN is the event that advances a calendar counter. The present SEC and MIN levels are also collected into a two-bit status word for a register read path. Every output is a register, or a tap of one, clocked by the time-base clock, and a synchronous active-high reset clears the whole chain.

The division ratios are parameters. The defaults give the real-time rates, and smaller values shorten a minute to a few hundred cycles for fast checking.

Top module: `rtc_prescaler`

## Requirements
- R1: While `rst` is high at a rising edge, every divider stage is cleared. In the cycle after that edge, `trim_o`, `sec_o`, `min_o`, `sec_fall_o`, `min_fall_o` and `status_o` all read 0.
- R2: `trim_o` is a 1:1 square wave with a period of 2^TRIM_LOG2 clock cycles (256 by default, which gives 128 Hz). It first reads 1 after 2^(TRIM_LOG2-1) rising edges following reset.
- R3: `sec_o` is a 1:1 square wave with a period of 2^SEC_LOG2 cycles (32768 by default, which gives 1 Hz). It reads 1 from edge 2^(SEC_LOG2-1) after reset and falls at edge 2^SEC_LOG2.
- R4: `min_o` changes state on every HALF_MIN-th falling edge of `sec_o` (30 by default), at the same clock edge where `sec_o` falls, and at no other time. It first rises after HALF_MIN seconds, so it has a 1:1 ratio with a 2*HALF_MIN second period.
- R5: `sec_fall_o` is high for exactly one cycle: the first cycle in which `sec_o` reads 0 after reading 1. It is low at all other times.
- R6: `min_fall_o` is high for exactly one cycle: the first cycle in which `min_o` reads 0 after reading 1. That cycle always coincides with a `sec_fall_o` cycle.
- R7: `status_o` bit 0 always equals `sec_o`, and bit 1 always equals `min_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz time-base clock |
| rst | input | 1 | Synchronous active-high reset |
| trim_o | output | 1 | Oscillator trimming square wave (128 Hz by default) |
| sec_o | output | 1 | Seconds square wave |
| min_o | output | 1 | Minute square wave, toggled by SEC falling edges |
| sec_fall_o | output | 1 | One-cycle strobe on each SEC falling edge |
| min_fall_o | output | 1 | One-cycle strobe on each MIN falling edge (calendar advance) |
| status_o | output | 2 | Readable levels: bit 1 MIN, bit 0 SEC |

## Verification
Every output is a register, or a direct tap of a register, that is updated on the edge which completes a count. Each result therefore shows up in the first cycle after the rising edge that completes it, with no extra latency. After n rising edges following reset, the reference model in the bench predicts `trim_o`, `sec_o`, `min_o` and both strobes from n alone, and it compares all of them at the falling clock edge of every cycle. A reduced instance makes a minute last 192 cycles, so several MIN periods are covered. A full-rate instance runs long enough to check the true 128 Hz tap and two 1 Hz SEC falls. A reset pulse in the middle of the run checks that both instances restart from a count of zero.

// File: rtl/rtc_prescale_pkg.sv
package rtc_prescale_pkg;

    // One slow timing signal: its level and a one-cycle strobe on its falling edge.
    typedef struct packed {
        logic level;
        logic fall;
    } wave_t;

    // Status word as seen by a register read path.
    typedef struct packed {
        logic min_lvl;
        logic sec_lvl;
    } rtc_status_t;

    // Counter width for a modulus of n states (at least one bit).
    function automatic int unsigned count_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/rtc_binary_divider.sv
module rtc_binary_divider
    import rtc_prescale_pkg::*;
#(
    parameter int unsigned SEC_LOG2  = 15,
    parameter int unsigned TRIM_LOG2 = 8
) (
    input  logic  clk,
    input  logic  rst,
    output logic  trim_o,
    output wave_t sec_o,
    output logic  sec_wrap_o
);
    logic [SEC_LOG2-1:0] cnt_q;
    logic                fall_q;
    logic                wrap_next;

    // All ones means the next edge brings the seconds tap from 1 to 0.
    assign wrap_next = &cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            fall_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
            fall_q <= wrap_next;
        end
    end

    assign trim_o     = cnt_q[TRIM_LOG2-1];
    assign sec_o      = '{level: cnt_q[SEC_LOG2-1], fall: fall_q};
    assign sec_wrap_o = wrap_next;
endmodule

// File: rtl/rtc_toggle_stage.sv
module rtc_toggle_stage
    import rtc_prescale_pkg::*;
#(
    parameter int unsigned DIVISOR = 30
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  advance_i,
    output wave_t wave_o,
    output logic  advance_o
);
    localparam int unsigned CW = count_width(DIVISOR);
    localparam logic [CW-1:0] LAST = CW'(DIVISOR - 1);

    logic [CW-1:0] cnt_q;
    logic          level_q;
    logic          fall_q;
    logic          toggle;

    assign toggle    = advance_i && (cnt_q == LAST);
    // The level falls on this edge when it toggles while high.
    assign advance_o = toggle && level_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            level_q <= 1'b0;
            fall_q  <= 1'b0;
        end else begin
            if (advance_i) begin
                cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
            end
            level_q <= level_q ^ toggle;
            fall_q  <= advance_o;
        end
    end

    assign wave_o = '{level: level_q, fall: fall_q};
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
    import rtc_prescale_pkg::*;
#(
    parameter int unsigned SEC_LOG2  = 15,
    parameter int unsigned TRIM_LOG2 = 8,
    parameter int unsigned HALF_MIN  = 30
) (
    input  logic       clk,
    input  logic       rst,
    output logic       trim_o,
    output logic       sec_o,
    output logic       min_o,
    output logic       sec_fall_o,
    output logic       min_fall_o,
    output logic [1:0] status_o
);
    wave_t       sec_w;
    wave_t       min_w;
    logic        sec_wrap;
    logic        min_wrap;
    rtc_status_t stat;

    rtc_binary_divider #(
        .SEC_LOG2 (SEC_LOG2),
        .TRIM_LOG2(TRIM_LOG2)
    ) u_div (
        .clk       (clk),
        .rst       (rst),
        .trim_o    (trim_o),
        .sec_o     (sec_w),
        .sec_wrap_o(sec_wrap)
    );

    rtc_toggle_stage #(
        .DIVISOR(HALF_MIN)
    ) u_min (
        .clk      (clk),
        .rst      (rst),
        .advance_i(sec_wrap),
        .wave_o   (min_w),
        .advance_o(min_wrap)
    );

    assign sec_o      = sec_w.level;
    assign sec_fall_o = sec_w.fall;
    assign min_o      = min_w.level;
    assign min_fall_o = min_w.fall;

    assign stat     = '{min_lvl: min_w.level, sec_lvl: sec_w.level};
    assign status_o = stat;
endmodule

// File: rtl/rtc_prescaler_checker.sv
module rtc_prescaler_checker (
    input logic clk,
    input logic rst,
    input logic sec,
    input logic min,
    input logic sec_fall,
    input logic min_fall
);
    // R1: the cycle after a reset edge shows quiet outputs
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> (!sec && !min && !sec_fall && !min_fall));

    // R3: a falling SEC level is always flagged by its strobe
    a_r3_sec_fall_flagged: assert property (@(posedge clk) disable iff (rst)
        $fell(sec) |-> sec_fall);

    // R4: MIN moves only together with a SEC falling edge
    a_r4_min_moves_on_sec_fall: assert property (@(posedge clk) disable iff (rst)
        !$stable(min) |-> sec_fall);

    // R5: the SEC strobe marks a real high-to-low change
    a_r5_sec_strobe_is_edge: assert property (@(posedge clk) disable iff (rst)
        sec_fall |-> (!sec && $past(sec)));

    // R6: the MIN strobe marks a real high-to-low change, coincident with SEC
    a_r6_min_strobe_is_edge: assert property (@(posedge clk) disable iff (rst)
        min_fall |-> (sec_fall && !min && $past(min)));
endmodule

bind rtc_prescaler rtc_prescaler_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .sec     (sec_o),
    .min     (min_o),
    .sec_fall(sec_fall_o),
    .min_fall(min_fall_o)
);

// File: tb/rtc_prescaler_tb_top.sv
module rtc_prescaler_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int S_SEC = 5;
    localparam int S_TRIM = 2;
    localparam int S_HALF = 3;
    localparam int F_SEC = 15;
    localparam int F_TRIM = 8;
    localparam int F_HALF = 30;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic armed = 1'b0;
    longint n = 0;
    int checks = 0;
    int fails = 0;

    logic s_trim, s_sec, s_min, s_sf, s_mf;
    logic [1:0] s_stat;
    logic f_trim, f_sec, f_min, f_sf, f_mf;
    logic [1:0] f_stat;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rtc_prescaler #(.SEC_LOG2(S_SEC), .TRIM_LOG2(S_TRIM), .HALF_MIN(S_HALF)) dut_i (
        .clk(clk), .rst(rst), .trim_o(s_trim), .sec_o(s_sec), .min_o(s_min),
        .sec_fall_o(s_sf), .min_fall_o(s_mf), .status_o(s_stat));

    rtc_prescaler dut_full_i (
        .clk(clk), .rst(rst), .trim_o(f_trim), .sec_o(f_sec), .min_o(f_min),
        .sec_fall_o(f_sf), .min_fall_o(f_mf), .status_o(f_stat));

    // Reference: count of rising edges since the last reset edge.
    always @(posedge clk) begin
        if (rst) n <= 0;
        else     n <= n + 1;
        armed <= 1'b1;
    end

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s at n=%0d: actual=%0b expected=%0b", tag, what, n, act, exp);
        end
    endtask

    task automatic check_inst(input string name, input int sl, input int tl, input int hm,
                              input logic trim, input logic sec, input logic min,
                              input logic sf, input logic mf, input logic [1:0] stat);
        longint per = longint'(1) << sl;
        longint s = n / per;
        logic e_trim = logic'((n >> (tl - 1)) & 1);
        logic e_sec = logic'((n >> (sl - 1)) & 1);
        logic e_min = logic'((s / hm) % 2);
        logic e_sf = (n > 0) && (n % per == 0);
        logic e_mf = e_sf && (s % (2 * hm) == 0);
        if (n == 0) begin
            chk("R1", {name, " reset trim"}, trim, 1'b0);
            chk("R1", {name, " reset sec"}, sec, 1'b0);
            chk("R1", {name, " reset min"}, min, 1'b0);
            chk("R1", {name, " reset strobes"}, sf | mf, 1'b0);
            chk("R1", {name, " reset status"}, |stat, 1'b0);
        end else begin
            chk("R2", {name, " trim"}, trim, e_trim);
            chk("R3", {name, " sec"}, sec, e_sec);
            chk("R4", {name, " min"}, min, e_min);
            chk("R5", {name, " sec_fall"}, sf, e_sf);
            chk("R6", {name, " min_fall"}, mf, e_mf);
            chk("R7", {name, " status sec bit"}, stat[0], e_sec);
            chk("R7", {name, " status min bit"}, stat[1], e_min);
        end
    endtask

    always @(negedge clk) begin
        if (armed) begin
            check_inst("small", S_SEC, S_TRIM, S_HALF, s_trim, s_sec, s_min, s_sf, s_mf, s_stat);
            if (n % 64 == 0 || f_sf || (n > 32700 && n < 32800) || (n > 65500 && n < 65600))
                check_inst("full", F_SEC, F_TRIM, F_HALF, f_trim, f_sec, f_min, f_sf, f_mf, f_stat);
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        repeat (450) @(posedge clk);
        #1 rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        repeat (70000) @(posedge clk);
        @(negedge clk);
        #1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog expired at n=%0d: actual=running expected=finished", n);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule